// File: doc/BRIEF.md
# Serial Result Output Port for a Sampling Converter

This block sends a 16-bit conversion result, most significant bit first, over a single serial data line. A converter core outside the block supplies the result word with a one-cycle done strobe, and a one-cycle start strobe when a new conversion begins. The port runs in one of two clocking arrangements, chosen by a static input. As clock master it divides the system clock into a bit clock, drives that clock out, and frames the word with a sync signal. As clock slave it follows a bit clock supplied from outside and shifts a serial input in behind the word, so several ports can share one data line in a chain.

Static inputs select the output coding (straight binary, or two's complement made by inverting the MSB), the polarity of the sync line, and inversion of the bit clock. In master mode another static input decides when the frame is sent. It can go out during the next conversion, carrying the previous result, or after the current conversion completes, carrying the new result. An active-low chip select takes away every output enable. The external bit clock and serial input are synchronized and edge-detected in the system clock domain, so the whole block runs on one clock.

Top module: `sop_serial_port`

## Requirements
- R1: The word is shifted out MSB first. With `straight_bin` = 1 it is sent unchanged. With `straight_bin` = 0, bit 15 is inverted and bits 14..0 are unchanged.
- R2: In master mode (`ext_clk_sel` = 0), each frame has exactly 16 active bit-clock edges. An active edge is a rise of `sclk_out` XOR `sclk_inv`. The bit period is 2*HALF_DIV system cycles. `sdout` carries bit 15-k at active edge k.
- R3: `sync_out` XOR `sync_inv` is 1 for exactly 16*2*HALF_DIV system cycles per master frame and 0 otherwise. It rises HALF_DIV cycles before the first active edge. When no frame is running, `sclk_out` rests at the level of `sclk_inv`.
- R4: `sclk_inv` = 1 inverts the master output clock. In slave mode it moves the shift edge of `sclk_in` from rising to falling, and the sampling edge from falling to rising.
- R5: With `read_during` = 0, a master frame starts on `conv_done` and carries the word presented with that strobe. `conv_start` starts no frame.
- R6: With `read_during` = 1, a master frame starts on `conv_start` and carries the word latched at the most recent `conv_done`. `conv_done` starts no frame.
- R7: A master trigger that arrives while a frame is running is ignored. The running frame still completes its 16 bits of the original word.
- R8: In slave mode (`ext_clk_sel` = 1), `conv_done` loads the coded word and its MSB appears on `sdout`. Each shift edge moves the next bit out. `sdin` is sampled on the sampling edge and enters at the LSB on the following shift edge. After 16 shift edges, `sdout` carries the `sdin` bits in the order they arrived.
- R9: While `cs_n` = 1, `sdout_oe`, `sclk_oe` and `sync_oe` are 0, and master triggers start no frame.
- R10: In slave mode, `sclk_oe` and `sync_oe` stay 0 and `sync_out` rests at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | One-cycle strobe: a conversion begins |
| conv_done | input | 1 | One-cycle strobe: `conv_result` is valid |
| conv_result | input | 16 | Result word from the converter core |
| straight_bin | input | 1 | 1: straight binary, 0: MSB inverted |
| ext_clk_sel | input | 1 | 0: master (own clock), 1: slave (external clock) |
| sync_inv | input | 1 | 0: sync active high, 1: sync active low |
| sclk_inv | input | 1 | Inverts the bit clock edges |
| read_during | input | 1 | Master: 1 sends during the next conversion, 0 sends after the conversion |
| cs_n | input | 1 | Active-low chip select |
| sclk_in | input | 1 | External bit clock (slave) |
| sdin | input | 1 | Chain input (slave) |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for `sdout` |
| sclk_out | output | 1 | Generated bit clock (master) |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| sync_out | output | 1 | Frame sync |
| sync_oe | output | 1 | Output enable for `sync_out` |

## Verification
Master frames are swept over every combination of sync polarity, clock inversion, coding and read timing, using words that differ per combination plus all-zero, all-one, MSB-only and LSB-only words. A wrong bit order, a missed MSB inversion, or an off-by-one in the bit count changes the captured word or the edge count. Each read-timing setting is also given the strobe it must ignore, and the word is swapped after latching, which shows whether the frame used the latched result or the live input. Slave runs clock out 32 bits with both edge polarities, using a distinct upstream word on `sdin`. This separates a one-edge skew in the chain path from a wrong choice of shift edge. Overlapping triggers and deselected triggers check that no frame restarts or appears.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // read timing for master frames
    typedef enum logic {
        RD_AFTER_CONV  = 1'b0,
        RD_DURING_CONV = 1'b1
    } rd_mode_e;

    // output coding: straight binary keeps the MSB, otherwise it flips
    function automatic logic coded_msb(input logic msb, input logic straight);
        return straight ? msb : ~msb;
    endfunction

endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sop_clkgen.sv
module sop_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic bit_end,
    output logic sclk_raw
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST_PH = CW'(PERIOD - 1);
    localparam logic [CW-1:0] MID_PH  = CW'(HALF_DIV);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        bit_end = st_q.run && (st_q.cnt == LAST_PH);
        if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (bit_end) begin
                st_d.cnt = '0;
                if (stop) st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        // low during the first half of a bit, high during the second half
        st_d.sclk = st_d.run && (st_d.cnt >= MID_PH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_raw = st_q.sclk;

    // R2: a bit ends only after a high phase of the clock
    assert_bit_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> st_q.sclk);
endmodule

// File: rtl/sop_shifter.sv
module sop_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic         msb
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)       sr_d = load_val;
        else if (shift) sr_d = {sr_q[W-2:0], shift_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb = sr_q[W-1];

    // R8: a load places the word's top bit on the line next cycle
    assert_load_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (msb == $past(load_val[W-1])));
    // R1: a shift brings the next lower bit to the line
    assert_shift_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (msb == $past(sr_q[W-2])));
endmodule

// File: rtl/sop_serial_port.sv
module sop_serial_port #(
    parameter int W           = 16,
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic         conv_done,
    input  logic [W-1:0] conv_result,
    input  logic         straight_bin,
    input  logic         ext_clk_sel,
    input  logic         sync_inv,
    input  logic         sclk_inv,
    input  logic         read_during,
    input  logic         cs_n,
    input  logic         sclk_in,
    input  logic         sdin,
    output logic         sdout,
    output logic         sdout_oe,
    output logic         sclk_out,
    output logic         sclk_oe,
    output logic         sync_out,
    output logic         sync_oe
);
    import sop_pkg::*;

    localparam int BW          = $clog2(W);
    localparam int FRAME_CYC   = W * 2 * HALF_DIV;
    localparam int LW          = $clog2(FRAME_CYC + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    typedef struct packed {
        logic          frame;
        logic [BW-1:0] bitn;
        logic [W-1:0]  res;
        logic          sdin_cap;
        logic          sclk_prev;
    } port_t;

    port_t st_d, st_q;

    // synchronized external signals
    logic [1:0] ext_raw, ext_lvl;
    assign ext_raw = {sdin, sclk_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_in_sync
            sop_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (ext_raw[g]),
                .dout (ext_lvl[g])
            );
        end
    endgenerate

    logic         sclk_lvl, sdin_lvl;
    logic         rise_ext, fall_ext, upd_edge, smp_edge;
    logic         slave_on, master_on;
    logic [W-1:0] coded;
    logic         trig, last_bit;
    logic         bit_end, sclk_raw;
    logic         sh_load, sh_shift, sh_in, sh_msb;
    logic [W-1:0] sh_val;

    assign sclk_lvl = ext_lvl[0];
    assign sdin_lvl = ext_lvl[1];

    always_comb begin
        st_d      = st_q;
        slave_on  = ext_clk_sel && !cs_n;
        master_on = !ext_clk_sel && !cs_n;

        coded        = conv_result;
        coded[W-1]   = coded_msb(conv_result[W-1], straight_bin);

        // edge detection on the oversampled external clock
        rise_ext = sclk_lvl && !st_q.sclk_prev;
        fall_ext = !sclk_lvl && st_q.sclk_prev;
        upd_edge = sclk_inv ? fall_ext : rise_ext;
        smp_edge = sclk_inv ? rise_ext : fall_ext;
        st_d.sclk_prev = sclk_lvl;

        // result latch for the read-during-conversion path
        if (conv_done) st_d.res = coded;

        // master frame trigger
        if (rd_mode_e'(read_during) == RD_DURING_CONV)
            trig = master_on && !st_q.frame && conv_start;
        else
            trig = master_on && !st_q.frame && conv_done;

        last_bit = (st_q.bitn == LAST_BIT);

        if (trig) begin
            st_d.frame = 1'b1;
            st_d.bitn  = '0;
        end else if (st_q.frame && bit_end) begin
            if (last_bit) st_d.frame = 1'b0;
            else          st_d.bitn  = st_q.bitn + 1'b1;
        end

        // chain input captured on the sampling edge
        if (slave_on && smp_edge) st_d.sdin_cap = sdin_lvl;

        // shift register control
        sh_load  = trig || (ext_clk_sel && conv_done);
        if (trig && (rd_mode_e'(read_during) == RD_DURING_CONV))
            sh_val = st_q.res;
        else
            sh_val = coded;
        sh_shift = (slave_on && upd_edge) ||
                   (!ext_clk_sel && st_q.frame && bit_end && !last_bit);
        sh_in    = ext_clk_sel ? st_q.sdin_cap : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sop_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (trig),
        .stop    (last_bit),
        .bit_end (bit_end),
        .sclk_raw(sclk_raw)
    );

    sop_shifter #(.W(W)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(sh_val),
        .shift   (sh_shift),
        .shift_in(sh_in),
        .msb     (sh_msb)
    );

    assign sdout    = sh_msb;
    assign sdout_oe = !cs_n;
    assign sclk_out = (ext_clk_sel ? 1'b0 : sclk_raw) ^ sclk_inv;
    assign sclk_oe  = !cs_n && !ext_clk_sel;
    assign sync_out = st_q.frame ^ sync_inv;
    assign sync_oe  = !cs_n && !ext_clk_sel;

    // frame length counter for the sync-width check
    logic [LW-1:0] sync_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sync_len_q <= '0;
        else if (st_q.frame) sync_len_q <= sync_len_q + 1'b1;
        else                 sync_len_q <= '0;
    end

    // R3: sync stays asserted for exactly one frame length
    assert_sync_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.frame) |-> (sync_len_q == LW'(FRAME_CYC)));
    // R3: the generated clock only toggles inside an asserted frame
    assert_sclk_inside_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_raw |-> st_q.frame);
    // R7: a running frame is never restarted
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.frame && !(bit_end && last_bit)) |=> (st_q.frame && $past(st_q.bitn) <= st_q.bitn));
    // R9: deselect removes every output enable
    assert_deselect_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdout_oe && !sclk_oe && !sync_oe));
    // R10: in slave mode the clock and sync are never driven
    assert_slave_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clk_sel |-> (!sclk_oe && !sync_oe));
endmodule

// File: tb/test_sop_serial_port.sv
module test_sop_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int HALF       = 2;
    localparam int FRAME      = W * 2 * HALF;
    localparam int HS         = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic conv_start = 0, conv_done = 0;
    logic [W-1:0] conv_result = '0;
    logic straight_bin = 1, ext_clk_sel = 0, sync_inv = 0, sclk_inv = 0;
    logic read_during = 0, cs_n = 1, sclk_in = 0, sdin = 0;
    logic sdout, sdout_oe, sclk_out, sclk_oe, sync_out, sync_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_serial_port #(.W(W), .HALF_DIV(HALF), .SYNC_STAGES(2)) i_sop_serial_port (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .straight_bin(straight_bin), .ext_clk_sel(ext_clk_sel),
        .sync_inv(sync_inv), .sclk_inv(sclk_inv), .read_during(read_during), .cs_n(cs_n),
        .sclk_in(sclk_in), .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sync_out(sync_out), .sync_oe(sync_oe)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // master-side protocol monitor
    int sync_cyc_tot = 0, bits_tot = 0;
    logic [W-1:0] cap = '0;
    logic lvl_prev = 1'b0;
    always @(negedge clk) begin
        logic lvl, syn;
        lvl = sclk_out ^ sclk_inv;
        syn = sync_out ^ sync_inv;
        if (rst_n && !ext_clk_sel) begin
            if (syn) sync_cyc_tot++;
            if (syn && lvl && !lvl_prev) begin
                cap = {cap[W-2:0], sdout};
                bits_tot++;
            end
        end
        lvl_prev = lvl;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done(input logic [W-1:0] w);
        conv_result = w; conv_done = 1'b1; tick(1); conv_done = 1'b0;
    endtask

    task automatic pulse_start();
        conv_start = 1'b1; tick(1); conv_start = 1'b0;
    endtask

    function automatic logic [W-1:0] expect_word(input logic [W-1:0] w, input logic sb);
        return sb ? w : {~w[W-1], w[W-2:0]};
    endfunction

    task automatic run_master(input logic [W-1:0] word, input logic si, input logic ci,
                              input logic sb, input logic rd);
        int s0, b0;
        sync_inv = si; sclk_inv = ci; straight_bin = sb; read_during = rd;
        ext_clk_sel = 0; cs_n = 0;
        tick(4);
        check("R3 idle sync level", 32'(sync_out), 32'(si));
        check("R3 R4 idle clock level", 32'(sclk_out), 32'(ci));
        s0 = sync_cyc_tot; b0 = bits_tot;
        if (!rd) begin
            pulse_start(); tick(20);
            check("R5 start strobe ignored", 32'(sync_cyc_tot - s0), 32'd0);
            pulse_done(word);
        end else begin
            pulse_done(word); tick(20);
            check("R6 done strobe ignored", 32'(sync_cyc_tot - s0), 32'd0);
            conv_result = ~word;
            pulse_start();
        end
        tick(FRAME + 10);
        check("R2 active edge count", 32'(bits_tot - b0), 32'd16);
        check(rd ? "R6 R1 latched word" : "R5 R1 new word", 32'(cap), 32'(expect_word(word, sb)));
        check("R3 sync width", 32'(sync_cyc_tot - s0), 32'(FRAME));
    endtask

    task automatic run_slave(input logic [W-1:0] word, input logic [W-1:0] up,
                             input logic ci, input logic sb);
        logic [2*W-1:0] got;
        ext_clk_sel = 1; sclk_inv = ci; straight_bin = sb; cs_n = 1;
        sclk_in = ~ci; sdin = 0;
        tick(6);
        pulse_done(word);
        tick(4); cs_n = 0; tick(4);
        check("R10 slave clock enable", 32'(sclk_oe), 32'd0);
        check("R10 slave sync enable", 32'(sync_oe), 32'd0);
        check("R10 slave sync inactive", 32'(sync_out), 32'(sync_inv));
        got = '0;
        for (int j = 0; j < 2*W; j++) begin
            sdin = (j < W) ? up[W-1-j] : 1'b0;
            tick(HS);
            sclk_in = ci;          // sampling edge
            tick(HS);
            got = {got[2*W-2:0], sdout};
            sclk_in = ~ci;         // shift edge
        end
        check(ci ? "R8 R4 R1 own word inverted clock" : "R8 R1 own word",
              32'(got[2*W-1:W]), 32'(expect_word(word, sb)));
        check(ci ? "R8 R4 chained word inverted clock" : "R8 chained word",
              32'(got[W-1:0]), 32'(up));
        cs_n = 1;
        tick(4);
    endtask

    initial begin
        int s0, b0;
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(2);
        // reset state, deselected
        check("R9 reset data enable", 32'(sdout_oe), 32'd0);
        check("R9 reset clock enable", 32'(sclk_oe), 32'd0);
        check("R9 reset sync enable", 32'(sync_oe), 32'd0);
        check("R3 reset sync inactive", 32'(sync_out), 32'd0);

        // sweep all master configurations
        for (int c = 0; c < 16; c++) begin
            run_master(16'hA5C3 ^ (16'(c) * 16'h1111), c[0], c[1], c[2], c[3]);
        end
        run_master(16'h0000, 0, 0, 1, 0);
        run_master(16'hFFFF, 1, 0, 0, 1);
        run_master(16'h8000, 0, 1, 1, 0);
        run_master(16'h0001, 1, 1, 0, 1);

        // R7: overlapping trigger ignored
        sync_inv = 0; sclk_inv = 0; straight_bin = 1; read_during = 0; cs_n = 0; ext_clk_sel = 0;
        tick(4);
        s0 = sync_cyc_tot; b0 = bits_tot;
        pulse_done(16'h3C5A);
        tick(20);
        pulse_done(16'hC3A5);
        tick(FRAME + 10);
        check("R7 overlap edge count", 32'(bits_tot - b0), 32'd16);
        check("R7 overlap word", 32'(cap), 32'h3C5A);
        check("R7 overlap sync width", 32'(sync_cyc_tot - s0), 32'(FRAME));
        // second word was still latched for a read-during frame
        read_during = 1;
        tick(2);
        pulse_start();
        tick(FRAME + 10);
        check("R6 R7 latched later word", 32'(cap), 32'hC3A5);

        // R9: deselected triggers
        read_during = 0; cs_n = 1;
        tick(2);
        check("R9 deselect data enable", 32'(sdout_oe), 32'd0);
        check("R9 deselect clock enable", 32'(sclk_oe), 32'd0);
        check("R9 deselect sync enable", 32'(sync_oe), 32'd0);
        s0 = sync_cyc_tot;
        pulse_done(16'h1234);
        tick(FRAME + 10);
        cs_n = 0;
        tick(10);
        check("R9 no frame while deselected", 32'(sync_cyc_tot - s0), 32'd0);
        check("R9 selected enables", 32'({sdout_oe, sclk_oe, sync_oe}), 32'h7);

        // slave and chain
        run_slave(16'hB38E, 16'h5A17, 0, 1);
        run_slave(16'h4C71, 16'hE2D9, 1, 1);
        run_slave(16'h0F0F, 16'h8001, 0, 0);
        run_slave(16'hF00D, 16'h7FFE, 1, 0);

        // back to master after slave use
        run_master(16'h6B2D, 0, 0, 1, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule